// File: doc/BRIEF.md
# Buffered PWM Channel

This block is one pulse-width-modulated output channel. A free-running power-of-two divider and two auxiliary tick inputs feed a clock selector. The selected tick advances a period counter. The counter either ramps up and wraps (edge-aligned) or climbs to the period value and falls back to zero (symmetric). The output sits at a programmable starting level while the counter is below the duty value and takes the opposite level otherwise.

Software writes the mode, duty and period words directly, one word per write strobe, through a small word-select port. A separate shadow word changes duty or period without a glitch. The mode word selects which of the two the shadow word targets, and the shadow value is copied into that target only when a new period begins. A one-cycle pulse marks each period start so that an interrupt block outside this one can count periods.

Top module: `pwm_slice`

## Requirements
- R1: After reset the mode, duty, period and counter outputs read zero, and `wave_out` and `period_end` are low.
- R2: `wr_sel` selects the written word: 0 mode, 1 duty, 2 period, 3 shadow update. In the mode word, bits 3:0 are the clock code, bit 8 the alignment, bit 9 the starting level and bit 10 the update target, and all other bits read back zero. A direct write is visible on `cfg_*` one cycle later.
- R3: A clock code k in 0..10 advances the counter on exactly one cycle in every 2^k cycles. Code 11 advances it once per `aux_tick_a` pulse and code 12 once per `aux_tick_b` pulse.
- R4: Clock codes 13, 14 and 15 never advance the counter.
- R5: With alignment 0 the counter runs 0, 1, …, P−1 and then returns to 0, so a period lasts P ticks.
- R6: With alignment 1 the counter runs up from 0 to P and back down to 1, and then returns to 0, so a period lasts 2·P ticks.
- R7: While the channel runs, `wave_out` equals the starting level (bit 9) when the counter is below the duty value, and its inverse otherwise.
- R8: The counter is held at 0 and `wave_out` equals the starting level on the cycle after `chan_en` is sampled low. After enable, counting resumes from 0.
- R9: With update target 0, a shadow write leaves the duty unchanged for the rest of the running period and loads it on the edge that returns the counter to 0.
- R10: With update target 1, a shadow write loads the period on the next period start, and the period just started already uses the new length.
- R11: `period_end` is high for exactly the cycle after each period wrap, and the counter reads 0 in that cycle.
- R12: While the channel is disabled, a pending shadow value is copied into its target on the clock edge that follows the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Channel run enable |
| aux_tick_a | input | 1 | Auxiliary tick A, one cycle per tick |
| aux_tick_b | input | 1 | Auxiliary tick B, one cycle per tick |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 2 | Word select (0 mode, 1 duty, 2 period, 3 shadow) |
| wr_data | input | DW | Write data |
| cfg_mode | output | 11 | Mode word readback |
| cfg_duty | output | DW | Active duty value |
| cfg_period | output | DW | Active period value |
| cnt_val | output | DW | Period counter |
| wave_out | output | 1 | PWM waveform |
| period_end | output | 1 | Period-start pulse |

## Verification
The bench aims at the turn points of both counting shapes. An off-by-one in the edge-aligned compare would stretch each period to P+1 ticks. A symmetric counter that turns one step late, or pauses at the top, would give a period that is not 2·P ticks. Shadow writes are placed in the middle of a period. A design that loads them at once would show the new duty or period before the counter wraps, and one that misses the boundary would never load them. The divider taps are checked at both ends of the range and the unused codes are checked for stall, which catches a selector that indexes off by one or lets an out-of-range code reach a divider tap.

// File: rtl/pwm_slice_pkg.sv
`timescale 1ns/1ps
package pwm_slice_pkg;
  localparam int unsigned MODE_W    = 11;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned ALIGN_BIT = 8;
  localparam int unsigned POL_BIT   = 9;
  localparam int unsigned TGT_BIT   = 10;
  localparam logic [MODE_W-1:0] MODE_MASK = 11'h70F;

  typedef enum logic [1:0] {
    SEL_MODE   = 2'd0,
    SEL_DUTY   = 2'd1,
    SEL_PERIOD = 2'd2,
    SEL_SHADOW = 2'd3
  } slice_sel_e;
endpackage

// File: rtl/pwm_slice_prescale.sv
`timescale 1ns/1ps
module pwm_slice_prescale #(
  parameter int unsigned STAGES = 10,
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              aux_a,
  input  logic              aux_b,
  output logic              adv
);
  localparam logic [CODE_W-1:0] CODE_AUX_A = CODE_W'(STAGES + 1);
  localparam logic [CODE_W-1:0] CODE_AUX_B = CODE_W'(STAGES + 2);

  logic [STAGES-1:0] div_q, div_d;
  logic [STAGES:0]   tap;

  always_comb div_d = div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  // tap k fires once every 2^k cycles
  assign tap[0] = 1'b1;
  generate
    for (genvar k = 1; k <= STAGES; k++) begin : g_tap
      assign tap[k] = &div_q[k-1:0];
    end
  endgenerate

  always_comb begin
    adv = 1'b0;
    for (int k = 0; k <= STAGES; k++) begin
      if (code == CODE_W'(k)) adv = tap[k];
    end
    if (code == CODE_AUX_A) adv = aux_a;
    if (code == CODE_AUX_B) adv = aux_b;
  end
endmodule

// File: rtl/pwm_slice_regs.sv
`timescale 1ns/1ps
module pwm_slice_regs
  import pwm_slice_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              chan_en,
  input  logic              boundary,
  output logic [MODE_W-1:0] mode_q,
  output logic [DW-1:0]     duty_q,
  output logic [DW-1:0]     period_q
);
  logic [MODE_W-1:0] mode_d;
  logic [DW-1:0]     duty_d, period_d, shadow_q, shadow_d;
  logic              pend_q, pend_d, apply;

  // shadow is released at a period start, or at once while idle
  always_comb apply = pend_q && (boundary || !chan_en);

  always_comb begin
    mode_d   = mode_q;
    duty_d   = duty_q;
    period_d = period_q;
    shadow_d = shadow_q;
    pend_d   = pend_q;
    if (apply) begin
      pend_d = 1'b0;
      if (mode_q[TGT_BIT]) period_d = shadow_q;
      else                 duty_d   = shadow_q;
    end
    if (wr_en) begin
      unique case (slice_sel_e'(wr_sel))
        SEL_MODE:   mode_d   = MODE_W'(wr_data) & MODE_MASK;
        SEL_DUTY:   duty_d   = wr_data;
        SEL_PERIOD: period_d = wr_data;
        SEL_SHADOW: begin
          shadow_d = wr_data;
          pend_d   = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      duty_q   <= '0;
      period_q <= '0;
      shadow_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      duty_q   <= duty_d;
      period_q <= period_d;
      shadow_q <= shadow_d;
      pend_q   <= pend_d;
    end
  end
endmodule

// File: rtl/pwm_slice_count.sv
`timescale 1ns/1ps
module pwm_slice_count #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          adv,
  input  logic          center,
  input  logic [DW-1:0] period,
  output logic [DW-1:0] cnt_q,
  output logic          run_q,
  output logic          boundary
);
  logic [DW-1:0] cnt_d;
  logic          up_q, up_d, run_d;
  logic [DW:0]   cnt_inc;

  always_comb cnt_inc = (DW+1)'(cnt_q) + 1'b1;

  always_comb begin
    cnt_d    = cnt_q;
    up_d     = up_q;
    run_d    = chan_en;
    boundary = 1'b0;
    if (!chan_en || !run_q) begin
      cnt_d = '0;
      up_d  = 1'b1;
    end else if (adv) begin
      if (!center) begin
        if (cnt_inc >= (DW+1)'(period)) begin
          cnt_d    = '0;
          boundary = 1'b1;
        end else begin
          cnt_d = cnt_inc[DW-1:0];
        end
      end else if (up_q && (cnt_q < period)) begin
        cnt_d = cnt_inc[DW-1:0];
      end else if (cnt_q <= DW'(1)) begin
        cnt_d    = '0;
        up_d     = 1'b1;
        boundary = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
        up_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
      run_q <= run_d;
    end
  end
endmodule

// File: rtl/pwm_slice.sv
`timescale 1ns/1ps
module pwm_slice
  import pwm_slice_pkg::*;
#(
  parameter int unsigned DW         = 16,
  parameter int unsigned PRE_STAGES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              aux_tick_a,
  input  logic              aux_tick_b,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  output logic [MODE_W-1:0] cfg_mode,
  output logic [DW-1:0]     cfg_duty,
  output logic [DW-1:0]     cfg_period,
  output logic [DW-1:0]     cnt_val,
  output logic              wave_out,
  output logic              period_end
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       adv, boundary, run_q;
  logic       pend_q, pend_d;
  logic       start_lvl;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pwm_slice_prescale #(.STAGES(PRE_STAGES), .CODE_W(CODE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_int_n),
    .code  (cfg_mode[CODE_W-1:0]),
    .aux_a (aux_tick_a),
    .aux_b (aux_tick_b),
    .adv   (adv)
  );

  pwm_slice_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .chan_en  (chan_en),
    .boundary (boundary),
    .mode_q   (cfg_mode),
    .duty_q   (cfg_duty),
    .period_q (cfg_period)
  );

  pwm_slice_count #(.DW(DW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chan_en  (chan_en),
    .adv      (adv),
    .center   (cfg_mode[ALIGN_BIT]),
    .period   (cfg_period),
    .cnt_q    (cnt_val),
    .run_q    (run_q),
    .boundary (boundary)
  );

  always_comb pend_d = boundary;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) pend_q <= 1'b0;
    else            pend_q <= pend_d;
  end
  assign period_end = pend_q;

  // output is decoded from flops only
  assign start_lvl = cfg_mode[POL_BIT];
  always_comb begin
    if (!run_q)                wave_out = start_lvl;
    else if (cnt_val < cfg_duty) wave_out = start_lvl;
    else                       wave_out = ~start_lvl;
  end
endmodule

// File: rtl/pwm_slice_chk.sv
`timescale 1ns/1ps
module pwm_slice_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chan_en,
  input logic          wr_en,
  input logic          boundary,
  input logic [10:0]   cfg_mode,
  input logic [DW-1:0] cfg_duty,
  input logic [DW-1:0] cfg_period,
  input logic [DW-1:0] cnt_val,
  input logic          wave_out,
  input logic          period_end
);
  AST_PARK_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !chan_en |=> cnt_val == '0); // R8
  AST_PARK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (!chan_en && !wr_en) |=> wave_out == $past(cfg_mode[9])); // R8
  AST_EDGE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n) period_end |-> cnt_val == '0); // R11
  AST_NO_CLOCK_STALL: assert property (@(posedge clk) disable iff (!rst_n) (chan_en && cfg_mode[3:0] >= 4'd13) |=> ($stable(cnt_val) || cnt_val == '0)); // R4
  AST_SHADOW_WAITS: assert property (@(posedge clk) disable iff (!rst_n) (chan_en && !wr_en && !boundary) |=> ($stable(cfg_duty) && $stable(cfg_period))); // R9
endmodule

bind pwm_slice pwm_slice_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .chan_en    (chan_en),
  .wr_en      (wr_en),
  .boundary   (boundary),
  .cfg_mode   (cfg_mode),
  .cfg_duty   (cfg_duty),
  .cfg_period (cfg_period),
  .cnt_val    (cnt_val),
  .wave_out   (wave_out),
  .period_end (period_end)
);

// File: tb/pwm_slice_test.sv
`timescale 1ns/1ps
module pwm_slice_test;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          chan_en, aux_tick_a, aux_tick_b, wr_en;
  logic [1:0]    wr_sel;
  logic [DW-1:0] wr_data;
  logic [10:0]   cfg_mode;
  logic [DW-1:0] cfg_duty, cfg_period, cnt_val;
  logic          wave_out, period_end;

  int tests_run = 0;
  int tests_failed = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_slice uut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .aux_tick_a(aux_tick_a), .aux_tick_b(aux_tick_b),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .cfg_mode(cfg_mode), .cfg_duty(cfg_duty), .cfg_period(cfg_period),
    .cnt_val(cnt_val), .wave_out(wave_out), .period_end(period_end)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [DW-1:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_on();
    chan_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_off();
    chan_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mode", 32'(cfg_mode), 0);
    chk("R1 duty", 32'(cfg_duty), 0);
    chk("R1 period", 32'(cfg_period), 0);
    chk("R1 count", 32'(cnt_val), 0);
    chk("R1 wave", 32'(wave_out), 0);
    chk("R1 pulse", 32'(period_end), 0);
  endtask

  task automatic t_regs();
    wr(2'd0, 16'hFFFF);
    chk("R2 mode mask", 32'(cfg_mode), 32'h70F);
    wr(2'd1, 16'h1234);
    chk("R2 duty", 32'(cfg_duty), 32'h1234);
    wr(2'd2, 16'h0055);
    chk("R2 period", 32'(cfg_period), 32'h55);
    wr(2'd0, 16'h0000);
  endtask

  task automatic t_left();
    wr(2'd2, 16'd4); wr(2'd1, 16'd2); wr(2'd0, 16'h0000);
    run_on();
    for (int i = 0; i < 9; i++) begin
      chk("R5 left count", 32'(cnt_val), i % 4);
      chk("R7 left wave", 32'(wave_out), ((i % 4) >= 2) ? 1 : 0);
      chk("R11 left pulse", 32'(period_end), (i > 0 && (i % 4) == 0) ? 1 : 0);
      step(1);
    end
    run_off();
    chk("R8 parked count", 32'(cnt_val), 0);
    chk("R8 parked wave", 32'(wave_out), 0);
  endtask

  task automatic t_center();
    wr(2'd2, 16'd3); wr(2'd1, 16'd2); wr(2'd0, 16'h0300);
    step(1);
    chk("R8 parked high", 32'(wave_out), 1);
    run_on();
    for (int i = 0; i < 13; i++) begin
      int p = i % 6;
      int c = (p <= 3) ? p : 6 - p;
      chk("R6 center count", 32'(cnt_val), c);
      chk("R7 center wave", 32'(wave_out), (c < 2) ? 1 : 0);
      chk("R11 center pulse", 32'(period_end), (i > 0 && p == 0) ? 1 : 0);
      step(1);
    end
    run_off();
  endtask

  task automatic t_clock();
    logic [DW-1:0] c0;
    wr(2'd2, 16'd2000); wr(2'd1, 16'd0);
    wr(2'd0, 16'h0002);
    run_on(); c0 = cnt_val; step(20);
    chk("R3 divide by 4", 32'(cnt_val), 32'(c0) + 5);
    run_off();
    wr(2'd0, 16'h000A);
    run_on(); c0 = cnt_val; step(3072);
    chk("R3 divide by 1024", 32'(cnt_val), 32'(c0) + 3);
    run_off();
    for (int sel = 11; sel <= 12; sel++) begin
      wr(2'd0, DW'(sel));
      run_on(); c0 = cnt_val;
      for (int k = 0; k < 5; k++) begin
        aux_tick_b = 1'b1;
        if (k < 3) aux_tick_a = 1'b1;
        step(1);
        aux_tick_a = 1'b0; aux_tick_b = 1'b0;
        step(1);
      end
      chk("R3 aux tick", 32'(cnt_val), 32'(c0) + ((sel == 11) ? 3 : 5));
      run_off();
    end
    for (int sel = 13; sel <= 15; sel++) begin
      wr(2'd0, DW'(sel));
      run_on(); step(40);
      aux_tick_a = 1'b1; aux_tick_b = 1'b1; step(3);
      aux_tick_a = 1'b0; aux_tick_b = 1'b0;
      chk("R4 dead code", 32'(cnt_val), 0);
      run_off();
    end
  endtask

  task automatic t_shadow_duty();
    wr(2'd2, 16'd8); wr(2'd1, 16'd2); wr(2'd0, 16'h0000);
    run_on();
    step(3);
    wr(2'd3, 16'd6);
    for (int i = 4; i < 8; i++) begin
      chk("R9 duty held", 32'(cfg_duty), 2);
      chk("R9 old duty wave", 32'(wave_out), 1);
      step(1);
    end
    chk("R9 duty loaded", 32'(cfg_duty), 6);
    chk("R9 wrap count", 32'(cnt_val), 0);
    step(2);
    chk("R9 new duty low", 32'(wave_out), 0);
    step(4);
    chk("R9 new duty high", 32'(wave_out), 1);
    run_off();
  endtask

  task automatic t_shadow_period();
    wr(2'd2, 16'd4); wr(2'd1, 16'd1); wr(2'd0, 16'h0400);
    run_on();
    step(1);
    wr(2'd3, 16'd6);
    chk("R10 period held", 32'(cfg_period), 4);
    step(1);
    chk("R10 period held", 32'(cfg_period), 4);
    step(1);
    chk("R10 period loaded", 32'(cfg_period), 6);
    chk("R10 wrap count", 32'(cnt_val), 0);
    chk("R11 wrap pulse", 32'(period_end), 1);
    step(1);
    chk("R11 pulse one cycle", 32'(period_end), 0);
    step(4);
    chk("R10 longer period", 32'(cnt_val), 5);
    step(1);
    chk("R10 new wrap", 32'(cnt_val), 0);
    run_off();
  endtask

  task automatic t_idle_shadow();
    wr(2'd0, 16'h0000); wr(2'd1, 16'd3);
    wr(2'd3, 16'd9);
    step(1);
    chk("R12 idle duty", 32'(cfg_duty), 9);
    wr(2'd0, 16'h0400);
    wr(2'd3, 16'd7);
    step(1);
    chk("R12 idle period", 32'(cfg_period), 7);
  endtask

  initial begin
    rst_n = 1'b0; chan_en = 1'b0; aux_tick_a = 1'b0; aux_tick_b = 1'b0;
    wr_en = 1'b0; wr_sel = 2'd0; wr_data = '0;
    step(3);
    rst_n = 1'b1;
    step(3);
    t_reset();
    t_regs();
    t_left();
    t_center();
    t_clock();
    t_shadow_duty();
    t_shadow_period();
    t_idle_shadow();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule